// File: doc/BRIEF.md
# Pulse-Distance IR Frame Transmitter

This block drives the baseband (already demodulated) waveform of a pulse-distance infrared remote-control frame. The output line is active low and rests high. A one-cycle start strobe sends a full frame. The full frame begins with a long low leader and a long high space. Then come 32 data bits: the address, the address inverted, the command and the command inverted, each byte least significant bit first. A short low stop mark ends the frame. A one-cycle repeat strobe sends the short repeat frame instead. It has a leader, a shorter space and the stop mark, and no data.

All durations are given in microseconds and converted to clock-cycle counts at elaboration from the clock-frequency parameter. A single down-counter is reloaded at every segment boundary. A separate saturating counter measures the high time since the last frame ended. A repeat frame never begins before that time reaches the minimum gap. The busy flag covers the whole transmission, including any gap wait. A one-cycle done pulse marks the end of every frame.

Top module: `ir_frame_tx`

## Requirements
- R1: After reset, and at any time while the asynchronous active-low reset is asserted, ir_o is high, busy_o is low and done_o is low; whenever busy_o is low ir_o is high.
- R2: A full frame drives ir_o low for LEAD_MK_C cycles (9000 us of clock) and then high for LEAD_SP_C cycles (4500 us).
- R3: Every data bit is a low mark of MARK_C cycles (560 us) followed by a high space of ZERO_C cycles (560 us) for a 0 or ONE_C cycles (1690 us) for a 1.
- R4: The 32 data bits of a full frame are sent in the order bit 0 first: word = {~cmd, cmd, ~addr, addr}, so addr bit 0 goes first and ~cmd bit 7 goes last.
- R5: Every frame ends with a low stop mark of MARK_C cycles. In the cycle ir_o returns high, done_o is high for exactly one cycle and busy_o is already low.
- R6: A repeat frame is LEAD_MK_C cycles low, REP_SP_C cycles high (2250 us), MARK_C cycles low, and carries no data bits.
- R7: A repeat strobe is ignored until at least one full frame has been started since reset.
- R8: start_i and repeat_i are ignored while busy_o is high. addr_i and cmd_i are captured only in the cycle a start is accepted.
- R9: A repeat frame's leader begins no sooner than GAP_C cycles (40000 us) after ir_o rose at the end of the previous frame. When the strobe arrives earlier, the leader begins exactly GAP_C cycles after that rise.
- R10: When start_i and repeat_i are both high in an idle cycle, a full frame is sent.
- R11: An accepted start drives ir_o low and busy_o high from the clock edge that samples the strobe. busy_o stays high until the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request for a full frame |
| repeat_i | input | 1 | One-cycle request for a repeat frame |
| addr_i | input | BYTE_W | Address byte, captured on an accepted start |
| cmd_i | input | BYTE_W | Command byte, captured on an accepted start |
| ir_o | output | 1 | Active-low frame waveform, idles high |
| busy_o | output | 1 | High while a frame or its gap wait is in progress |
| done_o | output | 1 | One-cycle pulse when the stop mark ends |

## Verification
Full frames are sent with all-zero and all-one bytes, where every space has the same length. They are also sent with several arithmetically generated address and command pairs, which mix short and long spaces and would expose a swapped byte, a reversed bit order or a missing inversion. Each waveform is cut into runs of equal level and decoded back into a 32-bit word. Repeat frames are requested right after a frame, to measure the enforced gap exactly, and well after it, when the leader must start at once. Strobes are also injected mid-frame with changed inputs, both strobes are raised together, and a frame is reset part-way.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_LEAD_MK, S_LEAD_SP, S_BIT_MK, S_BIT_SP, S_STOP_MK
  } tx_state_e;

  function automatic longint us_to_cyc(input longint clk_hz, input longint us);
    return (clk_hz * us) / 64'd1_000_000;
  endfunction
endpackage

// File: rtl/ir_tx_timer.sv
module ir_tx_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ir_tx_gap.sv
module ir_tx_gap #(
  parameter int unsigned LIMIT = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic ok_o
);
  localparam int unsigned GAP_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [GAP_W-1:0] TOP = GAP_W'(LIMIT - 1);

  logic [GAP_W-1:0] cnt_q;

  // saturates one below the limit so the leader lands exactly LIMIT cycles after the rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == TOP);
endmodule

// File: rtl/ir_tx_bitseq.sv
module ir_tx_bitseq #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                adv_i,
  input  logic [BYTE_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   cmd_i,
  output logic                bit_o,
  output logic                last_o,
  output logic [4*BYTE_W-1:0] word_o
);
  localparam int unsigned NB    = 4 * BYTE_W;
  localparam int unsigned IDX_W = $clog2(NB);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  logic [NB-1:0]    word_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      word_q <= {~cmd_i, cmd_i, ~addr_i, addr_i};
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign bit_o  = word_q[idx_q];
  assign last_o = (idx_q == LAST);
  assign word_o = word_q;
endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
  import ir_tx_pkg::*;
#(
  parameter longint      CLK_HZ     = 50_000_000,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned LEAD_MK_US = 9000,
  parameter int unsigned LEAD_SP_US = 4500,
  parameter int unsigned REP_SP_US  = 2250,
  parameter int unsigned MARK_US    = 560,
  parameter int unsigned ZERO_SP_US = 560,
  parameter int unsigned ONE_SP_US  = 1690,
  parameter int unsigned GAP_US     = 40000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              repeat_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] cmd_i,
  output logic              ir_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned NB        = 4 * BYTE_W;
  localparam int unsigned LEAD_MK_C = int'(us_to_cyc(CLK_HZ, LEAD_MK_US));
  localparam int unsigned LEAD_SP_C = int'(us_to_cyc(CLK_HZ, LEAD_SP_US));
  localparam int unsigned REP_SP_C  = int'(us_to_cyc(CLK_HZ, REP_SP_US));
  localparam int unsigned MARK_C    = int'(us_to_cyc(CLK_HZ, MARK_US));
  localparam int unsigned ZERO_C    = int'(us_to_cyc(CLK_HZ, ZERO_SP_US));
  localparam int unsigned ONE_C     = int'(us_to_cyc(CLK_HZ, ONE_SP_US));
  localparam int unsigned GAP_C     = int'(us_to_cyc(CLK_HZ, GAP_US));

  localparam int unsigned MAX_A   = (LEAD_MK_C > LEAD_SP_C) ? LEAD_MK_C : LEAD_SP_C;
  localparam int unsigned MAX_B   = (REP_SP_C > MARK_C) ? REP_SP_C : MARK_C;
  localparam int unsigned MAX_C   = (ZERO_C > ONE_C) ? ZERO_C : ONE_C;
  localparam int unsigned MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_SEG = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int unsigned CNT_W   = $clog2(MAX_SEG + 1);

  // reload values are length-1: the load cycle itself is the first cycle of the segment
  localparam logic [CNT_W-1:0] LEAD_MK_L = CNT_W'(LEAD_MK_C - 1);
  localparam logic [CNT_W-1:0] LEAD_SP_L = CNT_W'(LEAD_SP_C - 1);
  localparam logic [CNT_W-1:0] REP_SP_L  = CNT_W'(REP_SP_C - 1);
  localparam logic [CNT_W-1:0] MARK_L    = CNT_W'(MARK_C - 1);
  localparam logic [CNT_W-1:0] ZERO_L    = CNT_W'(ZERO_C - 1);
  localparam logic [CNT_W-1:0] ONE_L     = CNT_W'(ONE_C - 1);

  tx_state_e        st_q, st_d;
  logic             rep_q, rep_d;
  logic             sent_q, sent_d;
  logic             done_q, done_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             seq_load, seq_adv, seq_bit, seq_last;
  logic             gap_ok;
  logic [NB-1:0]    frame_word;

  ir_tx_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  ir_tx_gap #(.LIMIT(GAP_C)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (done_d),
    .ok_o    (gap_ok)
  );

  ir_tx_bitseq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seq_load),
    .adv_i  (seq_adv),
    .addr_i (addr_i),
    .cmd_i  (cmd_i),
    .bit_o  (seq_bit),
    .last_o (seq_last),
    .word_o (frame_word)
  );

  always_comb begin
    st_d     = st_q;
    rep_d    = rep_q;
    sent_d   = sent_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    seq_load = 1'b0;
    seq_adv  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_d     = S_LEAD_MK;
          tmr_load = 1'b1;
          tmr_val  = LEAD_MK_L;
          seq_load = 1'b1;
          rep_d    = 1'b0;
          sent_d   = 1'b1;
        end else if (repeat_i && sent_q) begin
          rep_d = 1'b1;
          if (gap_ok) begin
            st_d     = S_LEAD_MK;
            tmr_load = 1'b1;
            tmr_val  = LEAD_MK_L;
          end else begin
            st_d = S_GAP;
          end
        end
      end
      S_GAP: begin
        if (gap_ok) begin
          st_d     = S_LEAD_MK;
          tmr_load = 1'b1;
          tmr_val  = LEAD_MK_L;
        end
      end
      S_LEAD_MK: begin
        if (tmr_zero) begin
          st_d     = S_LEAD_SP;
          tmr_load = 1'b1;
          tmr_val  = rep_q ? REP_SP_L : LEAD_SP_L;
        end
      end
      S_LEAD_SP: begin
        if (tmr_zero) begin
          st_d     = rep_q ? S_STOP_MK : S_BIT_MK;
          tmr_load = 1'b1;
          tmr_val  = MARK_L;
        end
      end
      S_BIT_MK: begin
        if (tmr_zero) begin
          st_d     = S_BIT_SP;
          tmr_load = 1'b1;
          tmr_val  = seq_bit ? ONE_L : ZERO_L;
        end
      end
      S_BIT_SP: begin
        if (tmr_zero) begin
          st_d     = seq_last ? S_STOP_MK : S_BIT_MK;
          tmr_load = 1'b1;
          tmr_val  = MARK_L;
          seq_adv  = ~seq_last;
        end
      end
      S_STOP_MK: begin
        if (tmr_zero) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      rep_q  <= 1'b0;
      sent_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rep_q  <= rep_d;
      sent_q <= sent_d;
      done_q <= done_d;
    end
  end

  assign ir_o   = !(st_q inside {S_LEAD_MK, S_BIT_MK, S_STOP_MK});
  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/ir_frame_tx_chk.sv
module ir_frame_tx_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              repeat_i,
  input logic              ir_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              rep_i,
  input logic [WORD_W-1:0] word_i,
  input logic [31:0]       gap_cyc_i
);
  logic        seen_q;
  logic [31:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      if (!busy_o && start_i) seen_q <= 1'b1;
      if (done_o)                       hi_cnt_q <= 32'd1;
      else if (hi_cnt_q != '1)          hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  p_idle_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ir_o);

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ir_o && !busy_o && !$past(ir_o)));

  p_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !ir_o));

  p_no_early_repeat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && repeat_i && !start_i && !seen_q) |=> !busy_o);

  p_word_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(word_i));

  p_gap_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ir_o) && rep_i) |-> (hi_cnt_q >= gap_cyc_i));
endmodule

bind ir_frame_tx ir_frame_tx_chk #(.WORD_W(4 * BYTE_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .repeat_i  (repeat_i),
  .ir_o      (ir_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rep_i     (rep_q),
  .word_i    (frame_word),
  .gap_cyc_i (32'(GAP_C))
);

// File: tb/test_ir_frame_tx.sv
`timescale 1ns/1ps
module test_ir_frame_tx;
  localparam longint HZ   = 100_000;
  localparam int LEAD     = int'(HZ * 9000 / 1_000_000);
  localparam int LSP      = int'(HZ * 4500 / 1_000_000);
  localparam int RSP      = int'(HZ * 2250 / 1_000_000);
  localparam int MARK     = int'(HZ * 560 / 1_000_000);
  localparam int ZERO     = int'(HZ * 560 / 1_000_000);
  localparam int ONE      = int'(HZ * 1690 / 1_000_000);
  localparam int GAP      = int'(HZ * 40000 / 1_000_000);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, repeat_i = 1'b0;
  logic [7:0] addr_i = '0, cmd_i = '0;
  logic ir_o, busy_o, done_o;

  int n_cmp = 0, n_bad = 0;
  int runs [0:79];
  int nruns;
  int busy_low;
  logic busy_at_done;

  always #5 clk = ~clk;

  ir_frame_tx #(.CLK_HZ(HZ)) i_ir_frame_tx (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .repeat_i (repeat_i),
    .addr_i (addr_i), .cmd_i (cmd_i), .ir_o (ir_o), .busy_o (busy_o), .done_o (done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cuts ir_o into level runs from now until done_o; runs[0] is the leading high stretch
  task automatic grab();
    logic lvl;
    int len;
    nruns = 0; lvl = 1'b1; len = 0; busy_low = 0; busy_at_done = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      if (done_o) begin
        runs[nruns] = len; nruns++;
        busy_at_done = busy_o;
        return;
      end
      if (!busy_o) busy_low++;
      if (ir_o == lvl) len++;
      else begin
        if (nruns < 79) begin runs[nruns] = len; nruns++; end
        lvl = ir_o; len = 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_full(input logic [7:0] a, input logic [7:0] c);
    logic [31:0] exp_w, got_w;
    int bad_t;
    exp_w = {~c, c, ~a, a};
    got_w = '0; bad_t = 0;
    chk(nruns == 68, "R4 run count", nruns, 68);
    if (nruns != 68) return;
    chk(runs[0] == 0 && runs[1] == LEAD, "R2 leader mark", runs[1], LEAD);
    chk(runs[2] == LSP, "R2 leader space", runs[2], LSP);
    for (int i = 0; i < 32; i++) begin
      if (runs[3 + 2*i] != MARK) bad_t++;
      if (runs[4 + 2*i] == ONE) got_w[i] = 1'b1;
      else if (runs[4 + 2*i] != ZERO) bad_t++;
    end
    chk(bad_t == 0, "R3 bit timing", bad_t, 0);
    chk(got_w == exp_w, "R4 bit order", got_w, exp_w);
    chk(runs[67] == MARK && !busy_at_done, "R5 stop mark", runs[67], MARK);
    chk(busy_low == 0, "R11 busy span", busy_low, 0);
  endtask

  task automatic check_rep(input int prefix);
    chk(nruns == 4, "R6 run count", nruns, 4);
    if (nruns != 4) return;
    chk(runs[0] == prefix, "R9 gap", runs[0], prefix);
    chk(runs[1] == LEAD && runs[2] == RSP, "R6 leader", runs[2], RSP);
    chk(runs[3] == MARK && !busy_at_done, "R6 stop", runs[3], MARK);
  endtask

  task automatic send_full(input logic [7:0] a, input logic [7:0] c);
    addr_i = a; cmd_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; addr_i = ~a;
    grab();
    check_full(a, c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int idle_bad;
    #1;
    chk(ir_o && !busy_o && !done_o, "R1 in reset", {ir_o, busy_o, done_o}, 3'b100);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ir_o && !busy_o && !done_o, "R1 after reset", {ir_o, busy_o, done_o}, 3'b100);

    // R7: repeat before any full frame
    repeat_i = 1'b1; @(negedge clk); repeat_i = 1'b0;
    idle_bad = 0;
    for (int k = 0; k < 50; k++) begin
      if (busy_o || !ir_o) idle_bad++;
      @(negedge clk);
    end
    chk(idle_bad == 0, "R7 repeat ignored", idle_bad, 0);

    // sweep of full frames
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a, c;
      a = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 37 + 11) ^ 8'h57);
      c = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 91 + 34);
      send_full(a, c);
      @(negedge clk);
      chk(!done_o && !busy_o, "R5 done single", done_o, 0);
      repeat (3) @(negedge clk);
    end

    // R9 early repeat: strobe in the done cycle
    send_full(8'h57, 8'h22);
    repeat_i = 1'b1;
    @(negedge clk);
    repeat_i = 1'b0;
    chk(!done_o, "R5 done single", done_o, 0);
    grab();
    check_rep(GAP - 1);

    // R9 late repeat: gap already satisfied
    repeat (GAP + 50) @(negedge clk);
    repeat_i = 1'b1; @(negedge clk); repeat_i = 1'b0;
    grab();
    check_rep(0);

    // R8: strobes and new inputs mid-frame
    addr_i = 8'h3C; cmd_i = 8'hC3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    fork
      grab();
      begin
        repeat (2000) @(negedge clk);
        addr_i = 8'h99; cmd_i = 8'h11; start_i = 1'b1; repeat_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; repeat_i = 1'b0;
      end
    join
    check_full(8'h3C, 8'hC3);
    idle_bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (busy_o || !ir_o) idle_bad++;
    end
    chk(idle_bad == 0, "R8 busy strobes ignored", idle_bad, 0);

    // R10: both strobes together
    addr_i = 8'hA5; cmd_i = 8'h0F; start_i = 1'b1; repeat_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; repeat_i = 1'b0;
    grab();
    chk(nruns == 68, "R10 start priority", nruns, 68);
    check_full(8'hA5, 8'h0F);
    repeat (5) @(negedge clk);

    // R1: reset part-way through a frame, then R7 again
    addr_i = 8'h12; cmd_i = 8'h34; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (300) @(negedge clk);
    chk(!ir_o && busy_o, "R11 mid frame", {ir_o, busy_o}, 2'b01);
    rst_ni = 1'b0;
    #1;
    chk(ir_o && !busy_o && !done_o, "R1 reset mid frame", {ir_o, busy_o, done_o}, 3'b100);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    repeat_i = 1'b1; @(negedge clk); repeat_i = 1'b0;
    idle_bad = 0;
    for (int k = 0; k < 50; k++) begin
      if (busy_o || !ir_o) idle_bad++;
      @(negedge clk);
    end
    chk(idle_bad == 0, "R7 repeat ignored after reset", idle_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule